// File: doc/BRIEF.md
# Interrupt Status and Mask Register Bank

This block holds the interrupt state of a serial bus controller. Single-cycle event pulses from the controller core set bits in a sticky status register. Software acknowledges an event by writing a one to that bit. A mask selects which status bits can raise the interrupt line. The mask has no direct write path. One write-only port sets mask bits and a second write-only port clears them, so software never has to do a read-modify-write on the mask.

The block drives one level-sensitive interrupt line and one error-pending line. Both are registered. Register access uses a simple port of valid, write, address and write data. Read data comes back combinationally in the same cycle as the read request.

Top module: `intr_status_bank`

## Requirements
- R1: After reset the status and the mask are zero, and `irq_o` and `err_o` are low.
- R2: A one on `evt_i[k]` in a cycle sets status bit k at the next clock edge, and the bit stays set until it is cleared. The bit layout is: 0 transfer done, 1 data threshold, 2 no acknowledge, 3 timeout, 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.
- R3: A write to offset 0x10 clears exactly the status bits that are one in the written word. Zero bits leave their status bits unchanged.
- R4: A write to offset 0x24 sets the mask bits that are one in the written word. Zero bits leave the mask unchanged.
- R5: A write to offset 0x28 clears the mask bits that are one in the written word. Writing 0x3FF clears the whole mask.
- R6: A read (valid high, write low) returns the following on `reg_rdata`:
  - offset 0x10 returns the status, zero-extended;
  - offsets 0x24 and 0x28 both return the mask, zero-extended;
  - any other offset returns zero.
  
  When no read is requested, `reg_rdata` is zero.
- R7: Bit 8 of the status and of the mask always reads zero. Neither an event nor an enable write can set it. Write-data bits above bit 9 have no effect.
- R8: If an event pulse and a clearing status write hit the same bit in the same cycle, the bit stays set. Other bits named in that write are still cleared.
- R9: `irq_o` equals the OR of (status AND mask), registered. It therefore changes one cycle after the status or mask change that causes it.
- R10: `err_o` equals the OR of (status AND mask) over the error group {9, 7, 6, 5, 2}. It is registered with the same one-cycle lag as `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 10 | Event pulses from the controller core |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the read |
| irq_o | output | 1 | Level interrupt: any enabled status bit set |
| err_o | output | 1 | Any enabled error-group status bit set |

## Verification
The results are due at different times, and each check samples only at its due time:

| Result | When it is due |
|---|---|
| Read data | At the read itself, because the read path is combinational. The bench samples it 2 ns after driving the address, before the next clock edge. |
| Status and mask | Updated at the clock edge that captures the event or write, so they are read back in the following cycle. |
| `irq_o` and `err_o` | One edge later than the status and mask, because they are registered. |

The bench checks the interrupt lines at the falling edge that follows that second clock edge. It also checks `irq_o` at the falling edge just after the first edge, where `irq_o` must still hold its old value. Inputs change only on falling clock edges.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int unsigned SRC_W = 10;
  // Bits that exist as storage; bit 8 is reserved.
  localparam logic [SRC_W-1:0] SRC_IMPL = 10'h2FF;
  // Error group: arbitration lost, rx underflow, tx overflow, rx overflow, no-ack.
  localparam logic [SRC_W-1:0] SRC_ERR  = 10'h2E4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_EN,
    SEL_DIS
  } reg_sel_e;
endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
  import irqb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] EN_OFS   = 8'h24,
  parameter logic [ADDR_W-1:0] DIS_OFS  = 8'h28
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              rd_en,
  output logic              stat_we,
  output logic              set_we,
  output logic              clr_we
);
  always_comb begin
    if (!valid)                sel = SEL_NONE;
    else if (addr == STAT_OFS) sel = SEL_STAT;
    else if (addr == EN_OFS)   sel = SEL_EN;
    else if (addr == DIS_OFS)  sel = SEL_DIS;
    else                       sel = SEL_NONE;
  end

  assign rd_en   = valid && !write;
  assign stat_we = write && (sel == SEL_STAT);
  assign set_we  = write && (sel == SEL_EN);
  assign clr_we  = write && (sel == SEL_DIS);
endmodule

// File: rtl/irqb_status.sv
module irqb_status
  import irqb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] evt,
  input  logic             ack_we,
  input  logic [SRC_W-1:0] ack_data,
  output logic [SRC_W-1:0] st_q
);
  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    if (SRC_IMPL[i]) begin : g_impl
      logic en, nxt;
      // Event has priority over a clearing write.
      assign en  = evt[i] | (ack_we & ack_data[i]);
      assign nxt = evt[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  st_q[i] <= 1'b0;
        else if (en) st_q[i] <= nxt;
      end
    end else begin : g_rsvd
      logic unused_in;
      assign unused_in = evt[i] ^ ack_data[i];
      assign st_q[i]   = 1'b0;
    end
  end
endmodule

// File: rtl/irqb_mask.sv
module irqb_mask
  import irqb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [SRC_W-1:0] data,
  output logic [SRC_W-1:0] msk_q
);
  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    if (SRC_IMPL[i]) begin : g_impl
      logic set_b, clr_b, en, nxt;
      assign set_b = set_we & data[i];
      assign clr_b = clr_we & data[i];
      assign en    = set_b | clr_b;
      assign nxt   = set_b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  msk_q[i] <= 1'b0;
        else if (en) msk_q[i] <= nxt;
      end
    end else begin : g_rsvd
      logic unused_in;
      assign unused_in = data[i];
      assign msk_q[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/intr_status_bank.sv
module intr_status_bank
  import irqb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] EN_OFS   = 8'h24,
  parameter logic [ADDR_W-1:0] DIS_OFS  = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  evt_i,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              err_o
);
  localparam int unsigned PAD_W = DATA_W - SRC_W;

  reg_sel_e         sel;
  logic             rd_en, stat_we, set_we, clr_we;
  logic [SRC_W-1:0] wdat, st_q, msk_q, view;
  logic             irq_d, err_d;
  logic             unused_hi;

  assign wdat      = reg_wdata[SRC_W-1:0];
  assign unused_hi = ^reg_wdata[DATA_W-1:SRC_W];

  irqb_decode #(
    .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .EN_OFS(EN_OFS), .DIS_OFS(DIS_OFS)
  ) u_dec (
    .valid(reg_valid), .write(reg_write), .addr(reg_addr),
    .sel(sel), .rd_en(rd_en), .stat_we(stat_we), .set_we(set_we), .clr_we(clr_we)
  );

  irqb_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt_i),
    .ack_we(stat_we), .ack_data(wdat), .st_q(st_q)
  );

  irqb_mask u_msk (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .data(wdat), .msk_q(msk_q)
  );

  always_comb begin
    view = '0;
    if (rd_en) begin
      case (sel)
        SEL_STAT:        view = st_q;
        SEL_EN, SEL_DIS: view = msk_q;
        default:         view = '0;
      endcase
    end
  end
  assign reg_rdata = {{PAD_W{1'b0}}, view};

  always_comb begin
    irq_d = |(st_q & msk_q);
    err_d = |(st_q & msk_q & SRC_ERR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      irq_o <= irq_d;
      err_o <= err_d;
    end
  end
endmodule

// File: rtl/irqb_chk.sv
module irqb_chk
  import irqb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] EN_OFS   = 8'h24,
  parameter logic [ADDR_W-1:0] DIS_OFS  = 8'h28
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_W-1:0]  evt_i,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [SRC_W-1:0]  st_q,
  input logic [SRC_W-1:0]  msk_q,
  input logic              irq_o,
  input logic              err_o
);
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q | msk_q) & ~SRC_IMPL) == '0);

  // Also covers R2: every implemented event lands in status.
  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & SRC_IMPL)) |=>
      ((st_q & $past(evt_i & SRC_IMPL)) == $past(evt_i & SRC_IMPL)));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && reg_addr == STAT_OFS && evt_i == '0) |=>
      (st_q == ($past(st_q) & ~$past(reg_wdata[SRC_W-1:0]))));

  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && reg_write && (reg_addr == EN_OFS || reg_addr == DIS_OFS)) |=>
      $stable(msk_q));

  assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_o == |($past(st_q & msk_q))));

  assert_err_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (err_o == |($past(st_q & msk_q & SRC_ERR))));
endmodule

bind intr_status_bank irqb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STAT_OFS(STAT_OFS), .EN_OFS(EN_OFS), .DIS_OFS(DIS_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
  .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .st_q(st_q), .msk_q(msk_q),
  .irq_o(irq_o), .err_o(err_o)
);

// File: tb/sim_intr_status_bank.sv
module sim_intr_status_bank;
  localparam logic [9:0] IMPL = 10'h2FF;
  localparam logic [9:0] ERRG = 10'h2E4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  evt;
  logic        v, w;
  logic [7:0]  a;
  logic [31:0] wd, rd;
  logic        irq, err;
  logic [9:0]  st_m, mk_m;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 0;

  always #10 clk = ~clk;

  intr_status_bank u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .reg_valid(v), .reg_write(w), .reg_addr(a), .reg_wdata(wd),
    .reg_rdata(rd), .irq_o(irq), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle with optional simultaneous events; model per requirements.
  task automatic cyc(input logic wr, input logic [7:0] ad, input logic [31:0] d, input logic [9:0] ev);
    @(negedge clk);
    v = wr; w = wr; a = ad; wd = d; evt = ev;
    if (wr) begin
      case (ad)
        8'h10:   st_m = st_m & ~d[9:0];
        8'h24:   mk_m = mk_m | (d[9:0] & IMPL);
        8'h28:   mk_m = mk_m & ~d[9:0];
        default: ;
      endcase
    end
    st_m = st_m | (ev & IMPL);
    @(negedge clk);
    v = 1'b0; w = 1'b0; a = '0; wd = '0; evt = '0;
  endtask

  task automatic rd_chk(input logic [7:0] ad, input logic [31:0] exp, input string tag);
    @(negedge clk);
    v = 1'b1; w = 1'b0; a = ad;
    #2;
    chk(rd === exp, tag, rd, exp);
    v = 1'b0; a = '0;
  endtask

  task automatic out_chk(input string tag);
    @(negedge clk);
    chk(irq === |(st_m & mk_m), {tag, " irq R9"}, {31'd0, irq}, {31'd0, |(st_m & mk_m)});
    chk(err === |(st_m & mk_m & ERRG), {tag, " err R10"}, {31'd0, err}, {31'd0, |(st_m & mk_m & ERRG)});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt = '0; v = 0; w = 0; a = '0; wd = '0;
    st_m = '0; mk_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(8'h10, 32'h0, "R1 status after reset");
    rd_chk(8'h24, 32'h0, "R1 mask after reset");
    out_chk("R1");

    // R2 / R7: events with mask off, one bit at a time
    for (int i = 0; i < 10; i++) begin
      cyc(1'b0, 8'h00, 32'h0, 10'(1 << i));
      rd_chk(8'h10, {22'd0, st_m}, $sformatf("R2 R7 status after event %0d", i));
      out_chk("R2 masked");
    end
    chk(st_m == IMPL, "R7 model sanity", {22'd0, st_m}, {22'd0, IMPL});

    // R6: no read requested, unmapped offset
    @(negedge clk); a = 8'h10; v = 1'b0; #2;
    chk(rd === 32'h0, "R6 idle rdata", rd, 32'h0);
    a = '0;
    rd_chk(8'h14, 32'h0, "R6 unmapped offset");

    // R4 / R5 / R9 / R10: enable and disable each bit with all status set
    for (int i = 0; i < 10; i++) begin
      cyc(1'b1, 8'h24, 32'(1 << i), '0);
      rd_chk(8'h28, {22'd0, mk_m}, $sformatf("R4 R6 mask via disable offset bit %0d", i));
      out_chk($sformatf("R9 R10 enable bit %0d", i));
      cyc(1'b1, 8'h28, 32'(1 << i), '0);
      rd_chk(8'h24, {22'd0, mk_m}, $sformatf("R5 mask after disable bit %0d", i));
      out_chk("R5 disabled");
    end

    // R4 zeros leave mask, R7 upper bits ignored
    cyc(1'b1, 8'h24, 32'h005, '0);
    cyc(1'b1, 8'h24, 32'h000, '0);
    rd_chk(8'h24, 32'h005, "R4 zero write keeps mask");
    cyc(1'b1, 8'h24, 32'hFFFF_FC00, '0);
    rd_chk(8'h24, 32'h005, "R7 upper data bits ignored");
    cyc(1'b1, 8'h28, 32'h3FF, '0);
    rd_chk(8'h24, 32'h0, "R5 disable all");

    // R3: write-one-to-clear, one bit at a time
    for (int i = 0; i < 10; i++) begin
      cyc(1'b1, 8'h10, 32'(1 << i), '0);
      rd_chk(8'h10, {22'd0, st_m}, $sformatf("R3 clear bit %0d", i));
    end

    // R8: event beats clear on the same bit
    cyc(1'b0, 8'h00, 32'h0, 10'h3FF);
    cyc(1'b1, 8'h24, 32'h3FF, '0);
    cyc(1'b1, 8'h10, 32'h3FF, 10'h008);
    rd_chk(8'h10, 32'h008, "R8 collision keeps bit 3");
    out_chk("R8");
    cyc(1'b1, 8'h10, 32'h008, '0);
    rd_chk(8'h10, 32'h0, "R3 clear after collision");

    // R9: exact one-cycle lag on rise and fall
    cyc(1'b1, 8'h28, 32'h3FF, '0);
    cyc(1'b1, 8'h24, 32'h001, '0);
    @(negedge clk);
    cyc(1'b0, 8'h00, 32'h0, 10'h001);
    chk(irq === 1'b0, "R9 irq not yet raised", {31'd0, irq}, 32'h0);
    out_chk("R9 raised");
    cyc(1'b1, 8'h10, 32'h001, '0);
    chk(irq === 1'b1, "R9 irq not yet dropped", {31'd0, irq}, 32'h1);
    out_chk("R9 dropped");

    // R10: non-error source gives irq but not err
    cyc(1'b1, 8'h24, 32'h3FF, '0);
    cyc(1'b0, 8'h00, 32'h0, 10'h010);
    out_chk("R10 non-error source");
    cyc(1'b0, 8'h00, 32'h0, 10'h200);
    out_chk("R10 error source");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule